// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit, 8-input analog-to-digital converter in a microcontroller. Software writes one control byte that picks an input, turns the converter on and clears the completion flag. It reads the last result from a separate data byte. On the analog side the block selects the input mux, drives a track/hold strobe, and presents trial codes to a DAC/comparator pair. It resolves one result bit per clock from the single comparator bit it reads back, starting with the most significant bit.

Once the converter is on and its settling delay has run out, the block converts the selected input over and over in fixed 64-clock frames with no further software action. Each frame opens with a sampling window 31.5 clocks long. Any control write abandons the frame in flight and starts a new one. The halt request powers the converter down, and after wake-up the settling delay runs again. The wait request is ignored. The block raises no interrupt.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the control readback is 00h, the data byte is 00h, the track/hold strobe is low and the trial code is 00h.
- R2: Control byte layout: bits 2:0 select the input, bit 5 turns the converter on, and bit 7 is the completion flag. Bit 7 ignores writes, and bits 6, 4 and 3 read as 0 whatever was written.
- R3: A write that turns the converter on from off starts the first frame SETTLE_CYC clocks after the write edge. The completion flag of that frame rises SETTLE_CYC+64 clocks after the write edge.
- R4: A frame lasts 64 clocks. The track/hold strobe is high for frame cycles 0 to 30 and for the first half of cycle 31. It falls on the falling clock edge inside cycle 31 and stays low for the rest of the frame.
- R5: The trial codes run from the MSB down, one per clock, and a bit is kept when the comparator reports 1 (input at or above the trial code). The result equals the input, saturates at FFh for inputs at or above full scale with no other indication, and is 00h for a zero input.
- R6: While the converter is on, a new result lands every 64 clocks without software action, and the completion flag stays set across frames.
- R7: The data byte changes only on the edge that ends a frame and holds its value between such edges.
- R8: A control write clears the completion flag on its own edge. If the converter was already converting, the write restarts the frame at cycle 0 without a new settling delay, and the next result follows 64 clocks later.
- R9: Writing bit 5 as 0 stops conversion at once: the strobe stays low, no result is written, and the data byte keeps its value.
- R10: While the halt request is high no conversion runs. When it falls with the converter on, the settling delay runs again in full before the next frame.
- R11: The wait request has no effect on result timing or value.
- R12: The input select sent to the mux is taken from the control byte only at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte readback |
| data_rdata | output | DATA_W | Last conversion result |
| halt_req | input | 1 | Halt low-power request |
| wait_req | input | 1 | Wait low-power request (ignored) |
| ana_chan | output | CHAN_W | Analog input mux select |
| ana_sample | output | 1 | Track/hold strobe, high while tracking |
| ana_code | output | DATA_W | Trial code to the DAC |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |

## Verification
The bench samples the strobe on both sides of the falling edge in cycle 31. A design that rounded the sampling window to 31 or 32 clocks would show the wrong level at one of those points. It counts the edges from the write and from halt release to the first completion flag, which catches a block that skips the settling delay after wake-up or re-settles on an abort. It drives inputs of 0, 255 and above full scale, which exposes a comparator-polarity or saturation error. It also writes a new input select mid-frame and checks that the data byte does not move before the frame ends.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_SETTLE = 2'd1,
      ST_CONV   = 2'd2
   } conv_state_e;

   localparam int CSR_W        = 8;
   localparam int CSR_DONE_BIT = 7;
   localparam int CSR_EN_BIT   = 5;
endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
   parameter int SETTLE_CYC = 3750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired_o
);
   localparam int W = $clog2(SETTLE_CYC + 1);
   localparam logic [W-1:0] LAST = W'(SETTLE_CYC - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (start)   cnt_q <= '0;
      else if (run)     cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run && (cnt_q == LAST);
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq #(
   parameter int FRAME_CYC  = 64,
   parameter int SAMPLE_CYC = 31,
   parameter bit HALF_CUT   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run,
   input  logic                         restart,
   input  logic                         active,
   output logic [$clog2(FRAME_CYC)-1:0] cnt_o,
   output logic                         last_o,
   output logic                         sample_o
);
   localparam int CNT_W = $clog2(FRAME_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);
   localparam logic [CNT_W-1:0] SMP  = CNT_W'(SAMPLE_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!run || restart)   cnt_q <= '0;
      else if (cnt_q == LAST)     cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = active && (cnt_q == LAST);

   generate
      if (HALF_CUT) begin : g_half
         logic late_half_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) late_half_q <= 1'b0;
            else        late_half_q <= active && (cnt_q == SMP);
         end
         assign sample_o = active &&
                           ((cnt_q < SMP) || ((cnt_q == SMP) && !late_half_q));
      end else begin : g_whole
         assign sample_o = active && (cnt_q < SMP);
      end
   endgenerate
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 6,
   parameter int FIRST_TRIAL = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              cmp_i,
   input  logic              res_write,
   output logic [DATA_W-1:0] code_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [CNT_W-1:0] FT  = CNT_W'(FIRST_TRIAL);
   localparam logic [CNT_W-1:0] END = CNT_W'(FIRST_TRIAL + DATA_W);

   logic [DATA_W-1:0] sar_q, data_q, mask;
   logic [CNT_W-1:0]  off;
   logic              trial;

   assign trial = active && (cnt >= FT) && (cnt < END);
   assign off   = cnt - FT;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = trial && (off == CNT_W'(DATA_W - 1 - i));
   end

   assign code_o = trial ? (sar_q | mask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sar_q <= '0;
      else if (!active || cnt < FT) sar_q <= '0;
      else if (trial && cmp_i)     sar_q <= sar_q | mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q <= '0;
      else if (res_write) data_q <= sar_q;
   end

   assign data_o = data_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_conv_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CHAN_W     = 3,
   parameter int FRAME_CYC  = 64,
   parameter int SAMPLE_CYC = 31,
   parameter bit HALF_CUT   = 1'b1,
   parameter int SETTLE_CYC = 3750
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        ctrl_rdata,
   output logic [DATA_W-1:0] data_rdata,
   input  logic              halt_req,
   input  logic              wait_req,
   output logic [CHAN_W-1:0] ana_chan,
   output logic              ana_sample,
   output logic [DATA_W-1:0] ana_code,
   input  logic              cmp_i
);
   localparam int CNT_W       = $clog2(FRAME_CYC);
   localparam int FIRST_TRIAL = SAMPLE_CYC + 1;

   if (FRAME_CYC < FIRST_TRIAL + DATA_W + 1) begin : g_bad_frame
      $error("frame too short for sampling plus bit trials");
   end
   if (CHAN_W > 3 || CHAN_W < 1) begin : g_bad_chan
      $error("input select must fit bits 2:0 of the control byte");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("settling delay must be at least one clock");
   end

   conv_state_e       state_q, state_d;
   logic [CHAN_W-1:0] chan_q, chan_lat_q;
   logic              en_q, done_q, halt_q;
   logic              wr_en, halt_exit, settle_start, settle_done;
   logic              run, restart, active, frame_last, res_write, load_chan;
   logic [CNT_W-1:0]  cnt;

   wire unused_inputs = ^{wait_req, reg_wdata[7:6], reg_wdata[4:3]};

   assign wr_en     = reg_wdata[CSR_EN_BIT];
   assign halt_exit = halt_q && !halt_req;
   assign active    = (state_q == ST_CONV);

   always_comb begin
      state_d = state_q;
      if (halt_req)                                   state_d = ST_OFF;
      else if (reg_wr) begin
         if (!wr_en)                                  state_d = ST_OFF;
         else if (!en_q || halt_exit || state_q == ST_OFF) state_d = ST_SETTLE;
      end
      else if (halt_exit && en_q)                     state_d = ST_SETTLE;
      else if (state_q == ST_SETTLE && settle_done)   state_d = ST_CONV;
   end

   assign settle_start = (state_d == ST_SETTLE) && (state_q != ST_SETTLE);
   assign run          = (state_d == ST_CONV);
   assign restart      = run && (!active || reg_wr);
   assign res_write    = frame_last && run && !reg_wr;
   assign load_chan    = run && (restart || frame_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_OFF;
         chan_q     <= '0;
         chan_lat_q <= '0;
         en_q       <= 1'b0;
         done_q     <= 1'b0;
         halt_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         halt_q  <= halt_req;
         if (reg_wr) begin
            chan_q <= reg_wdata[CHAN_W-1:0];
            en_q   <= wr_en;
         end
         if (load_chan)
            chan_lat_q <= reg_wr ? reg_wdata[CHAN_W-1:0] : chan_q;
         if (reg_wr)         done_q <= 1'b0;
         else if (res_write) done_q <= 1'b1;
      end
   end

   sar_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (settle_start),
      .run       (state_q == ST_SETTLE),
      .expired_o (settle_done)
   );

   sar_frame_seq #(
      .FRAME_CYC (FRAME_CYC),
      .SAMPLE_CYC(SAMPLE_CYC),
      .HALF_CUT  (HALF_CUT)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .restart  (restart),
      .active   (active),
      .cnt_o    (cnt),
      .last_o   (frame_last),
      .sample_o (ana_sample)
   );

   sar_bit_engine #(
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .FIRST_TRIAL(FIRST_TRIAL)
   ) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cnt       (cnt),
      .cmp_i     (cmp_i),
      .res_write (res_write),
      .code_o    (ana_code),
      .data_o    (data_rdata)
   );

   assign ana_chan = chan_lat_q;

   always_comb begin
      ctrl_rdata = '0;
      ctrl_rdata[CHAN_W-1:0]  = chan_q;
      ctrl_rdata[CSR_EN_BIT]   = en_q;
      ctrl_rdata[CSR_DONE_BIT] = done_q;
   end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int CHAN_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              halt_req,
   input logic              done,
   input logic              ana_sample,
   input logic [DATA_W-1:0] ana_code,
   input logic [CHAN_W-1:0] ana_chan,
   input logic [DATA_W-1:0] data_rdata,
   input logic              res_write,
   input logic              load_chan
);
   assert_write_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !done);

   assert_done_rises_on_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(res_write));

   assert_data_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(res_write) |-> $stable(data_rdata));

   assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt_req) |-> (!ana_sample && ana_code == '0));

   assert_chan_frame_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ana_chan) |-> $past(load_chan));

   assert_no_sample_in_trials_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ana_code != '0) |-> !ana_sample);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .halt_req   (halt_req),
   .done       (ctrl_rdata[7]),
   .ana_sample (ana_sample),
   .ana_code   (ana_code),
   .ana_chan   (ana_chan),
   .data_rdata (data_rdata),
   .res_write  (res_write),
   .load_chan  (load_chan)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
   localparam int S = 3750;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       halt_req = 1'b0;
   logic       wait_req = 1'b0;
   logic [7:0] ctrl_rdata, data_rdata, ana_code;
   logic [2:0] ana_chan;
   logic       ana_sample, cmp;
   logic [8:0] vin [8];

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   assign cmp = (vin[ana_chan] >= {1'b0, ana_code});

   sar_conv_ctrl #(.SETTLE_CYC(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata), .halt_req(halt_req),
      .wait_req(wait_req), .ana_chan(ana_chan), .ana_sample(ana_sample),
      .ana_code(ana_code), .cmp_i(cmp)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic adv(input int m);
      repeat (m) @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(posedge clk);
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic set_halt(input logic v);
      halt_req = v;
      @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic t_reset;
      chk("R1 ctrl", ctrl_rdata, 8'h00);
      chk("R1 data", data_rdata, 8'h00);
      chk("R1 sample", ana_sample, 0);
      chk("R1 code", ana_code, 0);
   endtask

   task automatic t_first;
      vin[3] = 9'd100;
      wr(8'h23);
      chk("R2 readback", ctrl_rdata, 8'h23);
      adv(S - 1);
      chk("R3 no frame yet", ana_sample, 0);
      adv(1);
      chk("R3 frame start", ana_sample, 1);
      chk("R12 chan", ana_chan, 3);
      adv(30);
      chk("R4 cycle30", ana_sample, 1);
      @(posedge clk); #1;
      chk("R4 cycle31 first half", ana_sample, 1);
      @(negedge clk); #1;
      chk("R4 cycle31 second half", ana_sample, 0);
      adv(32);
      chk("R3 done not yet", ctrl_rdata[7], 0);
      adv(1);
      chk("R3 done", ctrl_rdata[7], 1);
      chk("R5 value", data_rdata, 100);
   endtask

   task automatic t_continuous;
      vin[3] = 9'd200;
      adv(63);
      chk("R7 hold", data_rdata, 100);
      chk("R6 done stays", ctrl_rdata[7], 1);
      adv(1);
      chk("R6 next result", data_rdata, 200);
   endtask

   task automatic t_saturate;
      vin[3] = 9'd300; adv(64);
      chk("R5 saturate", data_rdata, 8'hFF);
      vin[3] = 9'd0;   adv(64);
      chk("R5 zero", data_rdata, 8'h00);
      vin[3] = 9'd255; adv(64);
      chk("R5 full", data_rdata, 8'hFF);
   endtask

   task automatic t_abort;
      adv(10);
      vin[5] = 9'd77;
      wr(8'hFD);
      chk("R8 done cleared", ctrl_rdata[7], 0);
      chk("R2 ignored bits", ctrl_rdata, 8'h25);
      adv(63);
      chk("R8 no early result", ctrl_rdata[7], 0);
      chk("R7 data held", data_rdata, 8'hFF);
      adv(1);
      chk("R8 result", data_rdata, 77);
      chk("R8 done", ctrl_rdata[7], 1);
      chk("R12 new chan", ana_chan, 5);
   endtask

   task automatic t_disable;
      wr(8'h05);
      chk("R9 readback", ctrl_rdata, 8'h05);
      chk("R9 sample off", ana_sample, 0);
      adv(200);
      chk("R9 no done", ctrl_rdata[7], 0);
      chk("R9 data held", data_rdata, 77);
      chk("R9 still off", ana_sample, 0);
   endtask

   task automatic t_halt;
      wr(8'h25);
      adv(S + 64);
      chk("R10 pre-halt result", ctrl_rdata[7], 1);
      set_halt(1'b1);
      adv(5);
      chk("R10 halted sample", ana_sample, 0);
      chk("R10 halted code", ana_code, 0);
      wr(8'h25);
      adv(100);
      chk("R10 no done in halt", ctrl_rdata[7], 0);
      vin[5] = 9'd33;
      set_halt(1'b0);
      adv(S - 1);
      chk("R10 resettle", ana_sample, 0);
      adv(1);
      chk("R10 frame after resettle", ana_sample, 1);
      adv(64);
      chk("R10 result", data_rdata, 33);
   endtask

   task automatic t_wait;
      wait_req = 1'b1;
      vin[5] = 9'd150;
      adv(63);
      chk("R11 timing", data_rdata, 33);
      adv(1);
      chk("R11 result", data_rdata, 150);
      wait_req = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) vin[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      adv(2);
      t_reset();
      t_first();
      t_continuous();
      t_saturate();
      t_abort();
      t_disable();
      t_halt();
      t_wait();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule